// File: doc/BRIEF.md
# Wishbone to Request/Acknowledge Register Bridge

This block is a Wishbone classic slave that turns each Wishbone transfer into one transaction on a narrow register bus with request/acknowledge handshaking. The register bus serves a small peripheral register file with a 3-bit address and 8-bit data. The bridge launches a request with its address, direction and write byte. It holds them steady for as long as the peripheral needs, then completes the Wishbone cycle with a one-clock acknowledge and the returned byte.

The 32-bit Wishbone data paths are narrowed to one byte lane. Writes take lane 0 of the input. Reads return the byte zero-extended to the full output width. A write whose lane-0 select bit is clear finishes at once on the Wishbone side and is never passed to the peripheral.

If the master gives up a cycle while a register transaction is still pending, the bridge still waits for the peripheral to finish. It then goes idle without acknowledging the abandoned cycle.

Top module: `wb_regbus_bridge`

## Requirements
- R1: While reset is high and in the first cycle after it, `reg_req`, `wbs_ack` and `wbs_rdat` are all zero.
- R2: When idle and both `wbs_cyc` and `wbs_stb` are high, `reg_req` rises on the next clock edge. In the same cycle `reg_addr` equals `wbs_adr`, `reg_wr` equals `wbs_we`, and on writes `reg_wdata` equals `wbs_wdat[7:0]`.
- R3: While `reg_req` is high and `reg_ack` is low, `reg_req`, `reg_addr`, `reg_wr` and `reg_wdata` keep their values on the next cycle.
- R4: `reg_req` is low in the cycle after `reg_ack` is sampled high together with `reg_req`.
- R5: `wbs_ack` is high for exactly one clock, starting one cycle after `reg_ack` is sampled. With a peripheral latency of L idle cycles, the ack appears L+2 cycles after the master raises the strobe.
- R6: On a read, `wbs_rdat[7:0]` holds the byte from `reg_rdata` in the acknowledge cycle, and `wbs_rdat[31:8]` is zero.
- R7: A write with `wbs_sel[0]` low is acknowledged one cycle after the strobe, raises no `reg_req`, and leaves the peripheral register unchanged.
- R8: If `wbs_cyc` drops while a register transaction is pending, that transaction still completes. It produces no `wbs_ack`, and no new request is issued before its `reg_ack`.
- R9: A `reg_ack` that arrives while no request is pending produces no `wbs_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wbs_cyc | input | 1 | Wishbone cycle valid |
| wbs_stb | input | 1 | Wishbone strobe (slave selected) |
| wbs_we | input | 1 | Wishbone write enable, 1 = write |
| wbs_adr | input | 3 | Wishbone register address |
| wbs_wdat | input | 32 | Wishbone write data, lane 0 used |
| wbs_sel | input | 4 | Wishbone byte selects, bit 0 gates writes |
| wbs_ack | output | 1 | Wishbone normal termination, one clock |
| wbs_rdat | output | 32 | Wishbone read data, byte zero-extended |
| reg_req | output | 1 | Register bus request |
| reg_addr | output | 3 | Register bus address |
| reg_wr | output | 1 | Register bus direction, 1 = write |
| reg_wdata | output | 8 | Register bus write byte |
| reg_ack | input | 1 | Register bus acknowledge |
| reg_rdata | input | 8 | Register bus read byte, valid with ack on reads |

## Verification
The bench builds the bridge with its default widths: a 32-bit Wishbone side, an 8-bit register side and 3-bit addresses. With these widths, all eight registers are reachable and the zero upper 24 bits of the read word are visible. The peripheral model's latency is set per transfer from 0 to 9 cycles. Latency 0 exercises the fastest turnaround and back-to-back cycles. The longer latencies give room to drop the cycle mid-transaction and to inject a stray acknowledge while the bus is idle.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } wrb_state_t;
endpackage

// File: rtl/wrb_ctrl.sv
module wrb_ctrl
  import wrb_pkg::*;
#(
  parameter int AW    = 3,
  parameter int RB_DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc,
  input  logic             stb,
  input  logic             we,
  input  logic [AW-1:0]    adr,
  input  logic [RB_DW-1:0] lane_wdata,
  input  logic             lane_sel,
  input  logic             rb_ack,
  output logic             rb_req,
  output logic [AW-1:0]    rb_addr,
  output logic             rb_we,
  output logic [RB_DW-1:0] rb_wdata,
  output logic             wb_ack,
  output logic             cap_en
);
  wrb_state_t state;
  logic       orphan;
  logic       start;
  logic       masked;
  logic       live;

  assign start  = cyc && stb;
  assign masked = start && we && !lane_sel;
  assign live   = cyc && !orphan;
  assign cap_en = (state == ST_WAIT) && rb_ack && !rb_we && live;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rb_req   <= 1'b0;
      rb_addr  <= '0;
      rb_we    <= 1'b0;
      rb_wdata <= '0;
      wb_ack   <= 1'b0;
      orphan   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          wb_ack <= 1'b0;
          orphan <= 1'b0;
          if (masked) begin
            wb_ack <= 1'b1;
            state  <= ST_RESP;
          end else if (start) begin
            rb_req   <= 1'b1;
            rb_addr  <= adr;
            rb_we    <= we;
            rb_wdata <= lane_wdata;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!cyc) orphan <= 1'b1;
          if (rb_ack) begin
            rb_req <= 1'b0;
            if (live) begin
              wb_ack <= 1'b1;
              state  <= ST_RESP;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: begin
          wb_ack <= 1'b0;
          state  <= ST_IDLE;
        end
      endcase
    end
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    rb_req && !rb_ack |=> rb_req && $stable(rb_addr) && $stable(rb_we) && $stable(rb_wdata));

  // R4
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    rb_req && rb_ack |=> !rb_req);

  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack);

  // R7
  masked_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && masked |=> wb_ack && !rb_req);

  // R8
  orphan_chk: assert property (@(posedge clk) disable iff (rst)
    rb_req && rb_ack && !cyc |=> !wb_ack);

  // R9
  stray_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && rb_ack && !masked |=> !wb_ack);
endmodule

// File: rtl/wrb_rdata.sv
module wrb_rdata #(
  parameter int RB_DW = 8,
  parameter int WB_DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [RB_DW-1:0] rb_rdata,
  output logic [WB_DW-1:0] wb_rdat
);
  localparam int PAD_W = WB_DW - RB_DW;

  logic [RB_DW-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst) byte_q <= '0;
    else if (cap_en) byte_q <= rb_rdata;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign wb_rdat = {{PAD_W{1'b0}}, byte_q};
    end else begin : g_nopad
      assign wb_rdat = byte_q;
    end
  endgenerate

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> wb_rdat[RB_DW-1:0] == $past(rb_rdata));
endmodule

// File: rtl/wb_regbus_bridge.sv
module wb_regbus_bridge #(
  parameter int WB_DW = 32,
  parameter int RB_DW = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wbs_cyc,
  input  logic             wbs_stb,
  input  logic             wbs_we,
  input  logic [AW-1:0]    wbs_adr,
  input  logic [WB_DW-1:0] wbs_wdat,
  input  logic [WB_DW/8-1:0] wbs_sel,
  output logic             wbs_ack,
  output logic [WB_DW-1:0] wbs_rdat,
  output logic             reg_req,
  output logic [AW-1:0]    reg_addr,
  output logic             reg_wr,
  output logic [RB_DW-1:0] reg_wdata,
  input  logic             reg_ack,
  input  logic [RB_DW-1:0] reg_rdata
);
  logic cap_en;

  wrb_ctrl #(.AW(AW), .RB_DW(RB_DW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cyc        (wbs_cyc),
    .stb        (wbs_stb),
    .we         (wbs_we),
    .adr        (wbs_adr),
    .lane_wdata (wbs_wdat[RB_DW-1:0]),
    .lane_sel   (wbs_sel[0]),
    .rb_ack     (reg_ack),
    .rb_req     (reg_req),
    .rb_addr    (reg_addr),
    .rb_we      (reg_wr),
    .rb_wdata   (reg_wdata),
    .wb_ack     (wbs_ack),
    .cap_en     (cap_en)
  );

  wrb_rdata #(.RB_DW(RB_DW), .WB_DW(WB_DW)) u_rdata (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .rb_rdata (reg_rdata),
    .wb_rdat  (wbs_rdat)
  );

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wbs_ack |-> wbs_rdat[WB_DW-1:RB_DW] == '0);
endmodule

// File: tb/wb_regbus_bridge_test.sv
`timescale 1ns/1ps
module wb_regbus_bridge_test;
  localparam int WB_DW = 32;
  localparam int RB_DW = 8;
  localparam int AW    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wbs_cyc = 0, wbs_stb = 0, wbs_we = 0;
  logic [AW-1:0] wbs_adr = '0;
  logic [WB_DW-1:0] wbs_wdat = '0;
  logic [3:0] wbs_sel = '0;
  logic wbs_ack;
  logic [WB_DW-1:0] wbs_rdat;
  logic reg_req, reg_wr;
  logic [AW-1:0] reg_addr;
  logic [RB_DW-1:0] reg_wdata;
  logic reg_ack = 1'b0;
  logic [RB_DW-1:0] reg_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wb_regbus_bridge #(.WB_DW(WB_DW), .RB_DW(RB_DW), .AW(AW)) uut (
    .clk(clk), .rst(rst),
    .wbs_cyc(wbs_cyc), .wbs_stb(wbs_stb), .wbs_we(wbs_we),
    .wbs_adr(wbs_adr), .wbs_wdat(wbs_wdat), .wbs_sel(wbs_sel),
    .wbs_ack(wbs_ack), .wbs_rdat(wbs_rdat),
    .reg_req(reg_req), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata)
  );

  // peripheral register model
  logic [RB_DW-1:0] pmem [8];
  logic [RB_DW-1:0] exp_mem [8];
  int lat_cfg = 0;
  int lat_cnt = 0;
  logic stray = 1'b0;
  logic prev_req = 1'b0;
  int req_rises = 0;
  int ack_count = 0;
  int hold_err = 0;
  logic [AW-1:0] cap_addr = '0;
  logic cap_we = 1'b0;
  logic [RB_DW-1:0] cap_wdata = '0;

  always @(negedge clk) begin
    if (wbs_ack) ack_count++;
    if (rst) begin
      reg_ack = 1'b0;
      prev_req = 1'b0;
    end else begin
      if (reg_req && !prev_req) begin
        req_rises++;
        cap_addr = reg_addr; cap_we = reg_wr; cap_wdata = reg_wdata;
        lat_cnt = 0;
      end
      if (reg_req && (reg_addr != cap_addr || reg_wr != cap_we || reg_wdata != cap_wdata))
        hold_err++;
      if (reg_ack) begin
        reg_ack = 1'b0;
      end else if (reg_req) begin
        if (lat_cnt >= lat_cfg) begin
          reg_ack = 1'b1;
          if (reg_wr) begin
            pmem[reg_addr] = reg_wdata;
            reg_rdata = 8'($urandom);
          end else begin
            reg_rdata = pmem[reg_addr];
          end
        end else begin
          lat_cnt++;
        end
      end else if (stray) begin
        reg_ack = 1'b1;
        reg_rdata = 8'hEE;
        stray = 1'b0;
      end
      prev_req = reg_req;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_cycles(input bit we, input logic [3:0] sel, input int lat);
    if (we && !sel[0]) return 32'd1;
    return 32'(lat + 2);
  endfunction

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    return {24'h0, exp_mem[a]};
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic xfer(input bit we, input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [3:0] sel, input int lat);
    int n;
    int r0;
    bit fwd;
    fwd = !(we && !sel[0]);
    lat_cfg = lat;
    r0 = req_rises;
    step();
    wbs_cyc = 1; wbs_stb = 1; wbs_we = we; wbs_adr = a; wbs_wdat = d; wbs_sel = sel;
    n = 0;
    do begin step(); n++; end while (!wbs_ack && n < 50);
    chk(wbs_ack, "R5 ack seen", 32'(wbs_ack), 1);
    chk(n == int'(exp_cycles(we, sel, lat)), fwd ? "R5 ack latency" : "R7 masked latency",
        32'(n), exp_cycles(we, sel, lat));
    chk(!reg_req, "R4 req low at ack", 32'(reg_req), 0);
    if (!we) chk(wbs_rdat == exp_read(a), "R6 read data", wbs_rdat, exp_read(a));
    wbs_cyc = 0; wbs_stb = 0;
    step();
    chk(!wbs_ack, "R5 one-clock ack", 32'(wbs_ack), 0);
    chk(req_rises - r0 == (fwd ? 1 : 0), fwd ? "R2 one request" : "R7 no request",
        32'(req_rises - r0), fwd ? 1 : 0);
    if (fwd) begin
      chk(cap_addr == a && cap_we == we, "R2 address and direction",
          {28'h0, cap_we, cap_addr}, {28'h0, we, a});
      if (we) chk(cap_wdata == d[7:0], "R2 write lane 0", 32'(cap_wdata), 32'(d[7:0]));
    end
    if (we && sel[0]) exp_mem[a] = d[7:0];
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a0, r0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin
      pmem[i] = 8'(8'h10 + i);
      exp_mem[i] = 8'(8'h10 + i);
    end
    repeat (3) step();
    chk(!reg_req && !wbs_ack && wbs_rdat == 0, "R1 in reset", {31'h0, reg_req | wbs_ack}, 0);
    rst = 0;
    step();
    chk(!reg_req && !wbs_ack && wbs_rdat == 0, "R1 after reset", wbs_rdat, 0);

    // directed corners
    xfer(0, 3'd2, 32'h0, 4'hF, 0);
    xfer(1, 3'd5, 32'hDEADBE5A, 4'h1, 0);
    xfer(0, 3'd5, 32'h0, 4'h0, 0);
    xfer(1, 3'd5, 32'h000000C3, 4'hE, 3);   // R7 masked write
    xfer(0, 3'd5, 32'h0, 4'hF, 9);          // R7 register unchanged
    chk(pmem[5] == 8'h5A, "R7 peripheral unchanged", 32'(pmem[5]), 32'h5A);
    xfer(1, 3'd7, 32'hFFFFFF81, 4'hF, 9);
    xfer(0, 3'd7, 32'h0, 4'h0, 1);

    // R8 abandoned cycle
    lat_cfg = 6;
    a0 = ack_count; r0 = req_rises;
    step();
    wbs_cyc = 1; wbs_stb = 1; wbs_we = 0; wbs_adr = 3'd1; wbs_sel = 4'hF;
    step(); step();
    wbs_cyc = 0; wbs_stb = 0;
    step();
    wbs_cyc = 1; wbs_stb = 1; wbs_adr = 3'd6;
    for (int k = 0; k < 4; k++) begin
      step();
      chk(req_rises - r0 == 1, "R8 no new request while pending", 32'(req_rises - r0), 1);
    end
    begin
      int n = 0;
      while (!wbs_ack && n < 50) begin step(); n++; end
    end
    chk(wbs_rdat == exp_read(3'd6), "R8 data of live cycle", wbs_rdat, exp_read(3'd6));
    wbs_cyc = 0; wbs_stb = 0;
    repeat (3) step();
    chk(ack_count - a0 == 1, "R8 abandoned cycle not acked", 32'(ack_count - a0), 1);
    chk(req_rises - r0 == 2, "R8 both requests issued", 32'(req_rises - r0), 2);

    // R9 stray acknowledge
    a0 = ack_count; r0 = req_rises;
    stray = 1;
    repeat (4) step();
    chk(ack_count == a0, "R9 stray ack ignored", 32'(ack_count - a0), 0);
    chk(req_rises == r0, "R9 no request from stray ack", 32'(req_rises - r0), 0);
    xfer(0, 3'd6, 32'h0, 4'hF, 2);

    // random traffic
    for (int i = 0; i < 300; i++) begin
      xfer(1'($urandom), 3'($urandom), $urandom, 4'($urandom), int'($urandom % 6));
    end
    for (int i = 0; i < 8; i++) xfer(0, 3'(i), 32'h0, 4'hF, 0);

    chk(hold_err == 0, "R3 request fields held", 32'(hold_err), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule